// File: doc/BRIEF.md
# Work-Efficient Exclusive Scan Engine

The engine computes the prefix sum of one block of `ELEMS` unsigned words, where `ELEMS` is a power of two. The words arrive on a valid/ready input stream and are written into a padded internal scratchpad. A work-efficient two-phase tree then runs in place. The first phase is a reduction that climbs from the leaves to the root. The root is then set to zero. The second phase walks back down from the root and leaves the exclusive prefix of every element in the scratchpad. The tree work is spread over `LANES` adder lanes. Each tree level takes one cycle for every group of up to `LANES` pairs.

When the tree has finished, the results leave on a valid/ready output stream in index order, with the exclusive and the inclusive prefix side by side. The block total appears on `block_sum`, so that a higher-level controller can chain several blocks. That controller can scan the totals and feed each block's carry-in back through the offset input. When offset mode is selected at start, the offset is added to every output word.

Stream rules: an input word is taken on a clock edge where `in_valid` and `in_ready` are both high. An output word is consumed on an edge where `out_valid` and `out_ready` are both high. The source may pause the input stream at any time. While `out_ready` is low, the engine holds the output word and its valid flag steady.

Top module: `scan_engine`

## Requirements
- R1: One cycle after `start` is seen in idle, `in_ready` goes high. It stays high, including over cycles where `in_valid` is low, until exactly `ELEMS` words have been accepted. It then drops.
- R2: Output word i carries on `out_excl` the sum of input words 0 to i-1, modulo 2^W. Word 0 carries 0. The offset of R5 is added on top.
- R3: `out_incl` for word i equals the sum of input words 0 to i, modulo 2^W, plus the offset. This makes it equal to the `out_excl` of word i+1.
- R4: While the results are streamed, `block_sum` holds the sum of all `ELEMS` inputs modulo 2^W, without the offset. It does not change during the output stream.
- R5: `offset_en` and `offset_in` are sampled only in the cycle `start` is accepted. If `offset_en` was 1, `offset_in` is added to every `out_excl` and `out_incl` word. If it was 0, nothing is added. Changes to either input while busy have no effect.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_excl` and `out_incl` hold their values on the next cycle.
- R7: `busy` rises one cycle after an accepted `start` and falls one cycle after the handshake of the last output word. While `busy` is high, `start` is ignored. While `busy` is low, `in_ready` and `out_valid` are low.
- R8: All additions wrap modulo 2^W, and no carry is kept.
- R9: `in_ready` and `out_valid` are never high in the same cycle.
- R10: Let G be the sum, over tree levels l = 0 to log2(ELEMS)-1, of ceil((ELEMS >> (l+1)) / LANES). Then `out_valid` first rises 2G+1 clock edges after the edge that accepts the last input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new block (taken only when idle) |
| offset_en | input | 1 | Offset mode select, sampled at start |
| offset_in | input | W | Offset added to every output word in offset mode |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Engine accepts an input word |
| in_data | input | W | Input word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_excl | output | W | Exclusive prefix of the current index |
| out_incl | output | W | Inclusive prefix of the current index |
| block_sum | output | W | Total of the block, without offset |
| busy | output | 1 | Engine is between start and the end of its output stream |

## Verification
Most internal faults reach the ports at the first output handshake. A wrong add or a wrong address in the up-sweep corrupts the root, and so corrupts `block_sum` the moment `out_valid` rises. A fault in the down-sweep or the clear step shows as wrong `out_excl` words from the first affected index onward. The checker also requires each accepted `out_excl` to match the previous accepted `out_incl`. This catches a stale read or a misaligned neighbour read within one handshake. A miscounted level or group moves the rising edge of `out_valid` away from the predicted 2G+1 cycles, and the bench checks that edge on every cycle of the wait.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_LOAD, PH_UP, PH_CLEAR, PH_DOWN, PH_OUT
  } phase_t;

  // scratchpad word for element idx: one spare word inserted per bank row
  function automatic int padded(input int idx, input int bank_words);
    return idx + idx / bank_words;
  endfunction
endpackage

// File: rtl/scan_seq.sv
module scan_seq #(
  parameter int ELEMS = 64,
  parameter int LANES = 8,
  localparam int IDX_W  = $clog2(ELEMS),
  localparam int LEVELS = $clog2(ELEMS),
  localparam int LVL_W  = $clog2(LEVELS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 in_valid,
  input  logic                 out_ready,
  output scan_pkg::phase_t     phase,
  output logic [LVL_W-1:0]     lvl,
  output logic [IDX_W-1:0]     grp,
  output logic [IDX_W-1:0]     idx,
  output logic                 busy,
  output logic                 in_ready,
  output logic                 out_valid
);
  import scan_pkg::*;

  function automatic logic [IDX_W-1:0] last_group(input logic [LVL_W-1:0] l);
    int pairs;
    pairs = ELEMS >> (int'(l) + 1);
    return IDX_W'((pairs + LANES - 1) / LANES - 1);
  endfunction

  logic grp_done;
  assign grp_done = (grp == last_group(lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      lvl   <= '0;
      grp   <= '0;
      idx   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_LOAD;
          idx   <= '0;
        end
        PH_LOAD: if (in_valid) begin
          if (idx == IDX_W'(ELEMS - 1)) begin
            phase <= PH_UP;
            lvl   <= '0;
            grp   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        PH_UP: begin
          if (grp_done) begin
            grp <= '0;
            if (lvl == LVL_W'(LEVELS - 1)) phase <= PH_CLEAR;
            else                           lvl   <= lvl + 1'b1;
          end else begin
            grp <= grp + 1'b1;
          end
        end
        PH_CLEAR: begin
          phase <= PH_DOWN;
          grp   <= '0;
        end
        PH_DOWN: begin
          if (grp_done) begin
            grp <= '0;
            if (lvl == '0) begin
              phase <= PH_OUT;
              idx   <= '0;
            end else begin
              lvl <= lvl - 1'b1;
            end
          end else begin
            grp <= grp + 1'b1;
          end
        end
        PH_OUT: if (out_ready) begin
          if (idx == IDX_W'(ELEMS - 1)) phase <= PH_IDLE;
          else                          idx   <= idx + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy      = (phase != PH_IDLE);
  assign in_ready  = (phase == PH_LOAD);
  assign out_valid = (phase == PH_OUT);
endmodule

// File: rtl/scan_lane.sv
module scan_lane #(
  parameter int W          = 32,
  parameter int ELEMS      = 64,
  parameter int LANES      = 8,
  parameter int LANE       = 0,
  parameter int BANK_WORDS = 32,
  localparam int IDX_W  = $clog2(ELEMS),
  localparam int LEVELS = $clog2(ELEMS),
  localparam int LVL_W  = $clog2(LEVELS + 1),
  localparam int PADDED = ELEMS + ELEMS / BANK_WORDS,
  localparam int A_W    = $clog2(PADDED)
) (
  input  logic [LVL_W-1:0] lvl,
  input  logic [IDX_W-1:0] grp,
  input  logic             down,
  input  logic [W-1:0]     l_data,
  input  logic [W-1:0]     r_data,
  output logic             active,
  output logic [A_W-1:0]   l_addr,
  output logic [A_W-1:0]   r_addr,
  output logic [W-1:0]     l_new,
  output logic [W-1:0]     r_new
);
  int stride, pairs, pair;

  always_comb begin
    stride = 1 << lvl;
    pairs  = ELEMS >> (int'(lvl) + 1);
    pair   = int'(grp) * LANES + LANE;
    active = (pair < pairs);
    if (active) begin
      l_addr = A_W'(scan_pkg::padded(stride * (2 * pair + 1) - 1, BANK_WORDS));
      r_addr = A_W'(scan_pkg::padded(stride * (2 * pair + 2) - 1, BANK_WORDS));
    end else begin
      l_addr = '0;
      r_addr = '0;
    end
    // up-sweep: right <- left + right, left kept
    // down-sweep: left <- right, right <- left + right
    l_new = down ? r_data : l_data;
    r_new = r_data + l_data;
  end
endmodule

// File: rtl/scan_engine.sv
module scan_engine #(
  parameter int W          = 32,
  parameter int ELEMS      = 64,
  parameter int LANES      = 8,
  parameter int BANK_WORDS = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         offset_en,
  input  logic [W-1:0] offset_in,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_excl,
  output logic [W-1:0] out_incl,
  output logic [W-1:0] block_sum,
  output logic         busy
);
  import scan_pkg::*;

  localparam int IDX_W  = $clog2(ELEMS);
  localparam int LEVELS = $clog2(ELEMS);
  localparam int LVL_W  = $clog2(LEVELS + 1);
  localparam int PADDED = ELEMS + ELEMS / BANK_WORDS;
  localparam int A_W    = $clog2(PADDED);
  localparam logic [A_W-1:0] ROOT_A = A_W'(padded(ELEMS - 1, BANK_WORDS));

  phase_t           phase;
  logic [LVL_W-1:0] lvl;
  logic [IDX_W-1:0] grp, idx;

  scan_seq #(.ELEMS(ELEMS), .LANES(LANES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .out_ready(out_ready), .phase(phase), .lvl(lvl), .grp(grp), .idx(idx),
    .busy(busy), .in_ready(in_ready), .out_valid(out_valid)
  );

  logic [W-1:0]   mem [PADDED];
  logic [LANES-1:0] active;
  logic [A_W-1:0] l_addr [LANES];
  logic [A_W-1:0] r_addr [LANES];
  logic [W-1:0]   l_new  [LANES];
  logic [W-1:0]   r_new  [LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    scan_lane #(.W(W), .ELEMS(ELEMS), .LANES(LANES), .LANE(j),
                .BANK_WORDS(BANK_WORDS)) u_lane (
      .lvl(lvl), .grp(grp), .down(phase == PH_DOWN),
      .l_data(mem[l_addr[j]]), .r_data(mem[r_addr[j]]),
      .active(active[j]), .l_addr(l_addr[j]), .r_addr(r_addr[j]),
      .l_new(l_new[j]), .r_new(r_new[j])
    );
  end

  logic [A_W-1:0] load_a;
  assign load_a = A_W'(padded(int'(idx), BANK_WORDS));

  always_ff @(posedge clk) begin
    if (phase == PH_LOAD && in_valid) mem[load_a] <= in_data;
    if (phase == PH_UP || phase == PH_DOWN) begin
      for (int j = 0; j < LANES; j++) begin
        if (active[j]) begin
          mem[l_addr[j]] <= l_new[j];
          mem[r_addr[j]] <= r_new[j];
        end
      end
    end
    if (phase == PH_CLEAR) mem[ROOT_A] <= '0;
  end

  logic [W-1:0] off_q, sum_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      sum_q <= '0;
    end else begin
      if (phase == PH_IDLE && start) off_q <= offset_en ? offset_in : '0;
      if (phase == PH_CLEAR) sum_q <= mem[ROOT_A];
    end
  end

  // inclusive prefix of i is the exclusive prefix of i+1; the last one is the total
  logic           last_idx;
  logic [A_W-1:0] nxt_a;
  assign last_idx = (idx == IDX_W'(ELEMS - 1));
  assign nxt_a    = A_W'(padded(last_idx ? int'(idx) : int'(idx) + 1, BANK_WORDS));

  assign out_excl  = mem[load_a] + off_q;
  assign out_incl  = (last_idx ? sum_q : mem[nxt_a]) + off_q;
  assign block_sum = sum_q;
endmodule

// File: rtl/scan_engine_chk.sv
module scan_engine_chk #(
  parameter int W     = 32,
  parameter int ELEMS = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_excl,
  input logic [W-1:0] out_incl,
  input logic [W-1:0] block_sum
);
  localparam int CNT_W = $clog2(ELEMS) + 1;

  logic [CNT_W-1:0] load_cnt;
  logic             have_prev;
  logic [W-1:0]     prev_incl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_cnt  <= '0;
      have_prev <= 1'b0;
      prev_incl <= '0;
    end else begin
      if (!busy) load_cnt <= '0;
      else if (in_valid && in_ready) load_cnt <= load_cnt + 1'b1;
      if (!busy) have_prev <= 1'b0;
      else if (out_valid && out_ready) begin
        have_prev <= 1'b1;
        prev_incl <= out_incl;
      end
    end
  end

  assert_load_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && load_cnt == CNT_W'(ELEMS - 1)) |=> !in_ready);

  assert_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && have_prev) |-> out_excl == prev_incl);

  assert_sum_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(block_sum));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_excl) && $stable(out_incl));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!in_ready && !out_valid));

  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(out_valid && out_ready));

  assert_one_side_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
endmodule

bind scan_engine scan_engine_chk #(.W(W), .ELEMS(ELEMS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_excl(out_excl), .out_incl(out_incl), .block_sum(block_sum)
);

// File: tb/test_scan_engine.sv
module test_scan_engine;
  localparam int W      = 32;
  localparam int ELEMS  = 64;
  localparam int LANES  = 8;
  localparam int LEVELS = $clog2(ELEMS);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         offset_en = 1'b0;
  logic [W-1:0] offset_in = '0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         out_ready = 1'b0;
  logic         in_ready, out_valid, busy;
  logic [W-1:0] out_excl, out_incl, block_sum;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [W-1:0] stim [ELEMS];

  always #5 clk = ~clk;

  scan_engine #(.W(W), .ELEMS(ELEMS), .LANES(LANES), .BANK_WORDS(32)) i_scan_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .offset_en(offset_en),
    .offset_in(offset_in), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_excl(out_excl), .out_incl(out_incl), .block_sum(block_sum), .busy(busy)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R7 watchdog: actual=busy still pending expected=run complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int tree_groups();
    int g = 0;
    for (int l = 0; l < LEVELS; l++) g += ((ELEMS >> (l + 1)) + LANES - 1) / LANES;
    return g;
  endfunction

  task automatic run_block(input bit oen, input logic [W-1:0] off, input int gap, input int stall);
    logic [W-1:0] ex [ELEMS];
    logic [W-1:0] inc [ELEMS];
    logic [W-1:0] acc, eo;
    int wait_n, i, k;
    acc = '0;
    eo  = oen ? off : '0;
    for (int n = 0; n < ELEMS; n++) begin
      ex[n] = acc + eo;
      acc   = acc + stim[n];
      inc[n] = acc + eo;
    end
    wait_n = 2 * tree_groups() + 1;

    offset_en = oen; offset_in = off; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0; offset_en = ~oen; offset_in = ~off;  // R5: ignored while busy
    chk("R7 busy after start", busy, 1);
    chk("R1 in_ready after start", in_ready, 1);

    for (int n = 0; n < ELEMS; n++) begin
      if (gap > 0 && (n % gap) == gap - 1) begin
        in_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 in_ready held over gap", in_ready, 1);
      end
      in_valid = 1'b1; in_data = stim[n];
      @(posedge clk); @(negedge clk);
    end
    in_valid = 1'b0;

    for (int c = 0; c <= wait_n; c++) begin
      chk("R1 in_ready after last word", in_ready, 0);
      chk("R10 out_valid timing", out_valid, (c == wait_n) ? 1 : 0);
      chk("R7 busy while computing", busy, 1);
      if (c < wait_n) begin
        start = (c == 1);  // R7: start while busy is ignored
        @(posedge clk); @(negedge clk);
      end
    end
    start = 1'b0;

    i = 0; k = 0;
    while (i < ELEMS) begin
      chk("R6 out_valid", out_valid, 1);
      chk("R9 in_ready low in output", in_ready, 0);
      chk("R2 out_excl", out_excl, ex[i]);
      chk("R3 out_incl", out_incl, inc[i]);
      chk("R4 block_sum", block_sum, acc);
      out_ready = !(stall > 0 && (k % stall) == 0);
      k++;
      @(posedge clk); @(negedge clk);
      if (out_ready) i++;
    end
    out_ready = 1'b0;
    chk("R7 busy falls after last word", busy, 0);
    chk("R7 out_valid low when idle", out_valid, 0);
    chk("R4 block_sum after run", block_sum, acc);
  endtask

  initial begin
    logic [W-1:0] ex16 [16] = '{3, 11, 2, 5, 7, 0, 9, 3, 6, 15, 4, 7, 8, 10, 1, 2};
    logic [W-1:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset busy", busy, 0);
    chk("R1 reset in_ready", in_ready, 0);
    chk("R9 reset out_valid", out_valid, 0);
    chk("R4 reset block_sum", block_sum, 0);

    // R2 R4: repeated sample pattern, total 4*93
    for (int n = 0; n < ELEMS; n++) stim[n] = ex16[n % 16];
    run_block(1'b0, 32'h0, 0, 0);
    chk("R4 sample total", block_sum, 32'd372);

    // R8 wrap with all-ones words, R5 offset on, input gaps, stalls
    for (int n = 0; n < ELEMS; n++) stim[n] = 32'hFFFF_FFFF;
    run_block(1'b1, 32'd5, 3, 2);

    // R5 offset disabled although offset_in nonzero
    for (int n = 0; n < ELEMS; n++) stim[n] = (n * 32'h0101_0101) ^ 32'h00F0_0F00;
    run_block(1'b0, 32'hDEAD_BEEF, 0, 3);

    // pseudo-random words, large wrapping offset
    lfsr = 32'h1234_5678;
    for (int n = 0; n < ELEMS; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      stim[n] = lfsr * 32'd2654435761;
    end
    run_block(1'b1, 32'hFFFF_FFF0, 5, 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule